// File: doc/BRIEF.md
# Vectored Interrupt Priority Arbiter

This block collects interrupt requests for up to 256 vectors and decides when the attached processor core should be interrupted. It keeps three 256-bit arrays. The pending array records requested vectors. The in-service array records vectors the core has accepted but not yet retired. The trigger-mode array records whether each request was level- or edge-signalled. A larger vector number always wins. The winning vector of an array is its highest set bit.

The interrupt line goes high when three things hold. The best pending vector must outrank the best in-service vector. Its 16-vector class must also sit above the class of the task-priority register. Once raised, the line stays up until the core acknowledges. An acknowledge moves the winner from pending to in-service and reports its number. When nothing eligible remains, it reports a fixed spurious vector instead. An end-of-interrupt strobe retires the best in-service vector, but never the spurious one. The block also presents the processor priority, and a read port returns any array as 32-bit words.

Top module: `vec_prio_arb`

## Requirements
- R1: While rst_ni is low, all three arrays are cleared. tpr_o, ppr_o, intr_o and ack_vld_o are also zero.
- R2: A trigger (trig_i with vector trig_vec_i) sets pending bit v. It also writes trig_level_i (1 = level, 0 = edge) into trigger-mode bit v. Both are visible from the next clock edge.
- R3: An untrigger (untrig_i with untrig_vec_i) clears pending bit v at the next edge. It has no effect on the other arrays.
- R4: When intr_o is low and ack_i is low, intr_o rises at the next edge if three conditions hold in the current cycle. Some pending bit must be set. The top pending vector must exceed the top in-service vector, or no in-service bit is set. Finally, (top pending & 0xF0) must be greater than (tpr_o & 0xF0). Once high, intr_o stays high until an acknowledge.
- R5: An acknowledge may be granted. It is granted when a pending bit is set and (top pending & 0xF0) is greater than ppr_o. On the next edge the block then clears pending bit v and sets in-service bit v. It also pulses ack_vld_o for one cycle with ack_vec_o = v and drops intr_o.
- R6: An acknowledge that is not granted returns SPURIOUS_VEC (default 0xFF) with ack_vld_o and drops intr_o. It leaves all arrays unchanged.
- R7: eoi_i clears the top in-service bit. If that bit equals SPURIOUS_VEC it is kept, and with nothing in service the strobe does nothing.
- R8: tpr_we_i loads tpr_wdata_i into tpr_o at the next edge. If a lowered value makes a pending vector eligible, intr_o rises one edge later.
- R9: ppr_o equals tpr_o when tpr_o[7:4] >= top in-service vector[7:4], or when nothing is in service. Otherwise it equals the top in-service vector & 0xF0.
- R10: rd_data_o is combinational. Addresses 0x100, 0x180 and 0x200 are the bases of the in-service, trigger-mode and pending arrays. Each array spans eight words at a 0x10 stride, and address bits [3:0] are ignored. Bit b of word w is array bit 32*w+b. Any other address reads 0.
- R11: Only one event acts per cycle, with priority ack_i > eoi_i > tpr_we_i > untrig_i > trig_i. Lower-ranked requests in that cycle are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Request strobe |
| trig_vec_i | input | 8 | Vector to request |
| trig_level_i | input | 1 | 1 = level, 0 = edge |
| untrig_i | input | 1 | Withdraw strobe |
| untrig_vec_i | input | 8 | Vector to withdraw |
| ack_i | input | 1 | Core acknowledge |
| ack_vld_o | output | 1 | Acknowledge result valid |
| ack_vec_o | output | 8 | Acknowledged or spurious vector |
| eoi_i | input | 1 | End-of-interrupt strobe |
| tpr_we_i | input | 1 | Task-priority write enable |
| tpr_wdata_i | input | 8 | Task-priority write value |
| tpr_o | output | 8 | Current task priority |
| ppr_o | output | 8 | Processor priority |
| intr_o | output | 1 | Interrupt request to the core |
| rd_addr_i | input | 12 | Array word address |
| rd_data_o | output | 32 | Array word data |

## Verification
On every cycle, the assertions check several timing rules. An asserted intr_o holds until acknowledged, and an acknowledge always produces a one-cycle result pulse and a low intr_o. A task-priority write lands on the next edge, and the processor priority never falls below the task priority. Other behaviours depend on array contents and can only be shown by the bench's scenarios. These include which vector wins an acknowledge, the spurious fallback, the protected spurious in-service bit, the word layout of the read port and the dropping of lower-ranked simultaneous events. The bench checks them against a reference model.

// File: rtl/vpa_pkg.sv
package vpa_pkg;
  localparam int VEC_W   = 8;
  localparam int CLS_LSB = 4;

  typedef enum logic [2:0] {
    EV_NONE, EV_ACK, EV_EOI, EV_TPR, EV_UNTRIG, EV_TRIG
  } vpa_ev_e;

  function automatic logic [VEC_W-1:0] cls_of(input logic [VEC_W-1:0] v);
    return {v[VEC_W-1:CLS_LSB], {CLS_LSB{1'b0}}};
  endfunction
endpackage

// File: rtl/vpa_prio_enc.sv
module vpa_prio_enc #(
  parameter int N = 256,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  bits_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = 0; i < N; i++) begin
      if (bits_i[i]) begin
        valid_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/vpa_word_rd.sv
module vpa_word_rd #(
  parameter int NUM_VEC  = 256,
  parameter int WORD_W   = 32,
  parameter int ADDR_W   = 12,
  parameter int STRIDE   = 16,
  parameter int ISR_BASE = 'h100,
  parameter int TMR_BASE = 'h180,
  parameter int IRR_BASE = 'h200,
  localparam int WORDS   = NUM_VEC / WORD_W,
  localparam int OFF_W   = $clog2(STRIDE),
  localparam int WSEL_W  = $clog2(WORDS),
  localparam int REG_LSB = OFF_W + WSEL_W
) (
  input  logic [NUM_VEC-1:0] isr_i,
  input  logic [NUM_VEC-1:0] tmr_i,
  input  logic [NUM_VEC-1:0] irr_i,
  input  logic [ADDR_W-1:0]  addr_i,
  output logic [WORD_W-1:0]  data_o
);
  localparam int RW = ADDR_W - REG_LSB;

  logic [WSEL_W-1:0] wsel;
  logic [RW-1:0]     region;

  assign wsel   = addr_i[REG_LSB-1:OFF_W];
  assign region = addr_i[ADDR_W-1:REG_LSB];

  always_comb begin
    data_o = '0;
    if (region == RW'(ISR_BASE >> REG_LSB))
      data_o = isr_i[int'(wsel)*WORD_W +: WORD_W];
    else if (region == RW'(TMR_BASE >> REG_LSB))
      data_o = tmr_i[int'(wsel)*WORD_W +: WORD_W];
    else if (region == RW'(IRR_BASE >> REG_LSB))
      data_o = irr_i[int'(wsel)*WORD_W +: WORD_W];
  end
endmodule

// File: rtl/vec_prio_arb.sv
module vec_prio_arb
  import vpa_pkg::*;
#(
  parameter int               WORD_W       = 32,
  parameter int               ADDR_W       = 12,
  parameter logic [VEC_W-1:0] SPURIOUS_VEC = 8'hFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  logic [VEC_W-1:0]  trig_vec_i,
  input  logic              trig_level_i,
  input  logic              untrig_i,
  input  logic [VEC_W-1:0]  untrig_vec_i,
  input  logic              ack_i,
  output logic              ack_vld_o,
  output logic [VEC_W-1:0]  ack_vec_o,
  input  logic              eoi_i,
  input  logic              tpr_we_i,
  input  logic [VEC_W-1:0]  tpr_wdata_i,
  output logic [VEC_W-1:0]  tpr_o,
  output logic [VEC_W-1:0]  ppr_o,
  output logic              intr_o,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o
);
  localparam int NUM_VEC = 2 ** VEC_W;

  logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
  logic [VEC_W-1:0]   tpr_q, ack_vec_q;
  logic               intr_q, ack_vld_q;

  logic             irr_vld, isr_vld;
  logic [VEC_W-1:0] irr_top, isr_top;
  logic [VEC_W-1:0] ppr;
  logic             deliver, ack_ok;
  vpa_ev_e          ev;

  vpa_prio_enc #(.N(NUM_VEC)) u_irr_enc (.bits_i(irr_q), .valid_o(irr_vld), .idx_o(irr_top));
  vpa_prio_enc #(.N(NUM_VEC)) u_isr_enc (.bits_i(isr_q), .valid_o(isr_vld), .idx_o(isr_top));

  vpa_word_rd #(
    .NUM_VEC(NUM_VEC), .WORD_W(WORD_W), .ADDR_W(ADDR_W)
  ) u_rd (
    .isr_i(isr_q), .tmr_i(tmr_q), .irr_i(irr_q),
    .addr_i(rd_addr_i), .data_o(rd_data_o)
  );

  // processor priority: task priority or in-service class, whichever is higher
  always_comb begin
    ppr = tpr_q;
    if (isr_vld && (tpr_q[VEC_W-1:CLS_LSB] < isr_top[VEC_W-1:CLS_LSB]))
      ppr = cls_of(isr_top);
  end

  assign deliver = irr_vld
                 && (!isr_vld || (irr_top > isr_top))
                 && (cls_of(irr_top) > cls_of(tpr_q));
  assign ack_ok  = irr_vld && (cls_of(irr_top) > ppr);

  always_comb begin
    if      (ack_i)    ev = EV_ACK;
    else if (eoi_i)    ev = EV_EOI;
    else if (tpr_we_i) ev = EV_TPR;
    else if (untrig_i) ev = EV_UNTRIG;
    else if (trig_i)   ev = EV_TRIG;
    else               ev = EV_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q     <= '0;
      isr_q     <= '0;
      tmr_q     <= '0;
      tpr_q     <= '0;
      ack_vec_q <= '0;
      ack_vld_q <= 1'b0;
      intr_q    <= 1'b0;
    end else begin
      ack_vld_q <= (ev == EV_ACK);
      intr_q    <= (ev == EV_ACK) ? 1'b0 : (intr_q | deliver);
      case (ev)
        EV_ACK: begin
          ack_vec_q <= ack_ok ? irr_top : SPURIOUS_VEC;
          if (ack_ok) begin
            irr_q[irr_top] <= 1'b0;
            isr_q[irr_top] <= 1'b1;
          end
        end
        EV_EOI: if (isr_vld && (isr_top != SPURIOUS_VEC)) isr_q[isr_top] <= 1'b0;
        EV_TPR: tpr_q <= tpr_wdata_i;
        EV_UNTRIG: irr_q[untrig_vec_i] <= 1'b0;
        EV_TRIG: begin
          irr_q[trig_vec_i] <= 1'b1;
          tmr_q[trig_vec_i] <= trig_level_i;
        end
        default: ;
      endcase
    end
  end

  assign tpr_o     = tpr_q;
  assign ppr_o     = ppr;
  assign intr_o    = intr_q;
  assign ack_vld_o = ack_vld_q;
  assign ack_vec_o = ack_vec_q;
endmodule

// File: rtl/vec_prio_arb_chk.sv
module vec_prio_arb_chk #(
  parameter int VW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ack_i,
  input logic          eoi_i,
  input logic          tpr_we_i,
  input logic [VW-1:0] tpr_wdata_i,
  input logic          ack_vld_o,
  input logic [VW-1:0] tpr_o,
  input logic [VW-1:0] ppr_o,
  input logic          intr_o
);
  assert_reset_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!intr_o && !ack_vld_o && tpr_o == '0));

  assert_intr_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (intr_o && !ack_i) |=> intr_o);

  assert_ack_drops_intr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> (!intr_o && ack_vld_o));

  assert_ack_pulse_only_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_i |=> !ack_vld_o);

  assert_tpr_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tpr_we_i && !ack_i && !eoi_i) |=> (tpr_o == $past(tpr_wdata_i)));

  assert_ppr_floor_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ppr_o >= tpr_o);
endmodule

bind vec_prio_arb vec_prio_arb_chk #(.VW(8)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ack_i(ack_i), .eoi_i(eoi_i),
  .tpr_we_i(tpr_we_i), .tpr_wdata_i(tpr_wdata_i), .ack_vld_o(ack_vld_o),
  .tpr_o(tpr_o), .ppr_o(ppr_o), .intr_o(intr_o)
);

// File: tb/vec_prio_arb_tb_top.sv
module vec_prio_arb_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        trig_i = 0, trig_level_i = 0, untrig_i = 0, ack_i = 0, eoi_i = 0, tpr_we_i = 0;
  logic [7:0]  trig_vec_i = 0, untrig_vec_i = 0, tpr_wdata_i = 0;
  logic        ack_vld_o, intr_o;
  logic [7:0]  ack_vec_o, tpr_o, ppr_o;
  logic [11:0] rd_addr_i = 0;
  logic [31:0] rd_data_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [255:0] m_irr, m_isr, m_tmr;
  logic [7:0]   m_tpr, m_ackv;
  logic         m_intr, m_ackvld;

  always #2 clk_i = ~clk_i;

  vec_prio_arb dut_i (.*);

  function automatic int top_of(logic [255:0] a);
    int r = -1;
    for (int i = 0; i < 256; i++) if (a[i]) r = i;
    return r;
  endfunction

  function automatic logic [7:0] ppr_f(logic [7:0] t, logic [255:0] s);
    int si = top_of(s);
    if (si < 0 || t[7:4] >= si[7:4]) return t;
    return 8'(si) & 8'hF0;
  endfunction

  function automatic bit dlv_f(logic [255:0] r, logic [255:0] s, logic [7:0] t);
    int ri = top_of(r);
    int si = top_of(s);
    if (ri < 0) return 0;
    if (si >= 0 && ri <= si) return 0;
    return (8'(ri) & 8'hF0) > (t & 8'hF0);
  endfunction

  function automatic logic [31:0] rd_f(logic [11:0] a);
    int w = int'(a[6:4]);
    case (a[11:7])
      5'h02: return m_isr[w*32 +: 32];
      5'h03: return m_tmr[w*32 +: 32];
      5'h04: return m_irr[w*32 +: 32];
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_irr = '0; m_isr = '0; m_tmr = '0; m_tpr = 0; m_ackv = 0; m_intr = 0; m_ackvld = 0;
  endtask

  // one clock: drive, advance model by R11 priority, compare at the next negedge
  task automatic cyc(bit a, bit e, bit tw, logic [7:0] td, bit u, logic [7:0] uv,
                     bit t, logic [7:0] tv, bit lv, logic [11:0] ra);
    int ri;
    logic [7:0] pp;
    bit dl;
    ack_i = a; eoi_i = e; tpr_we_i = tw; tpr_wdata_i = td;
    untrig_i = u; untrig_vec_i = uv; trig_i = t; trig_vec_i = tv; trig_level_i = lv;
    rd_addr_i = ra;
    ri = top_of(m_irr);
    pp = ppr_f(m_tpr, m_isr);
    dl = dlv_f(m_irr, m_isr, m_tpr);
    m_ackvld = a;
    m_intr = a ? 1'b0 : (m_intr | dl);
    if (a) begin
      if (ri >= 0 && ((8'(ri) & 8'hF0) > pp)) begin
        m_ackv = 8'(ri); m_irr[ri] = 0; m_isr[ri] = 1;
      end else m_ackv = 8'hFF;
    end else if (e) begin
      int si = top_of(m_isr);
      if (si >= 0 && si != 255) m_isr[si] = 0;
    end else if (tw) m_tpr = td;
    else if (u) m_irr[uv] = 0;
    else if (t) begin m_irr[tv] = 1; m_tmr[tv] = lv; end
    @(posedge clk_i);
    @(negedge clk_i);
    chk("R4 intr", 32'(intr_o), 32'(m_intr));
    chk("R5 ack_vld", 32'(ack_vld_o), 32'(m_ackvld));
    if (m_ackvld) chk("R6 ack_vec", 32'(ack_vec_o), 32'(m_ackv));
    chk("R8 tpr", 32'(tpr_o), 32'(m_tpr));
    chk("R9 ppr", 32'(ppr_o), 32'(ppr_f(m_tpr, m_isr)));
    chk("R10 rd", rd_data_o, rd_f(ra));
  endtask

  task automatic idle(logic [11:0] ra);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, ra);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 0;
    model_reset();
    @(negedge clk_i);
    chk("R1 intr", 32'(intr_o), 0);
    chk("R1 tpr", 32'(tpr_o), 0);
    chk("R1 ppr", 32'(ppr_o), 0);
    rd_addr_i = 12'h200; #0;
    chk("R1 irr", rd_data_o, 0);
    rst_ni = 1;
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0A1C));
    model_reset();
    do_reset();

    // R2: level trigger lands in pending and trigger-mode words
    cyc(0,0,0,0,0,0,1,8'h45,1,12'h1A0);
    chk("R2 tmr word2", rd_data_o, 32'h20);
    chk("R4 not yet", 32'(intr_o), 0);
    idle(12'h220);
    chk("R2 irr word2", rd_data_o, 32'h20);
    chk("R4 intr up", 32'(intr_o), 1);
    // R5: grant
    cyc(1,0,0,0,0,0,0,0,0,12'h120);
    chk("R5 vec", 32'(ack_vec_o), 32'h45);
    chk("R5 isr", rd_data_o, 32'h20);
    chk("R5 intr low", 32'(intr_o), 0);
    // R6: nothing pending
    cyc(1,0,0,0,0,0,0,0,0,12'h120);
    chk("R6 spurious", 32'(ack_vec_o), 32'hFF);
    chk("R6 isr kept", rd_data_o, 32'h20);
    // R7: retire, then empty EOI ignored
    cyc(0,1,0,0,0,0,0,0,0,12'h120);
    chk("R7 cleared", rd_data_o, 0);
    cyc(0,1,0,0,0,0,0,0,0,12'h120);
    // R8: class equal to task priority blocks, lowering releases
    cyc(0,0,1,8'h50,0,0,0,0,0,12'h000);
    cyc(0,0,0,0,0,0,1,8'h52,0,12'h000);
    idle(12'h000); idle(12'h000);
    chk("R8 blocked", 32'(intr_o), 0);
    cyc(0,0,1,8'h40,0,0,0,0,0,12'h000);
    idle(12'h000);
    chk("R8 released", 32'(intr_o), 1);
    cyc(1,0,0,0,0,0,0,0,0,12'h000);
    chk("R5 vec52", 32'(ack_vec_o), 32'h52);
    chk("R9 isr class", 32'(ppr_o), 32'h50);
    // R11: ack wins over a same-cycle trigger
    cyc(1,0,0,0,0,0,1,8'h53,0,12'h220);
    chk("R11 trig dropped", rd_data_o, 0);
    // R11: eoi wins over tpr write
    cyc(0,1,1,8'h10,0,0,0,0,0,12'h120);
    chk("R11 tpr kept", 32'(tpr_o), 32'h40);
    chk("R7 eoi done", rd_data_o, 0);
    // R3: withdraw
    cyc(0,0,0,0,0,0,1,8'h10,0,12'h200);
    cyc(0,0,0,0,1,8'h10,0,0,0,12'h200);
    chk("R3 withdrawn", rd_data_o, 0);
    // R10: unmapped address
    idle(12'h300);
    chk("R10 unmapped", rd_data_o, 0);
    idle(12'h20C);
    chk("R10 low bits ignored", rd_data_o, 0);

    // random traffic checked against the model
    for (int k = 0; k < 3000; k++) begin
      int r = int'($urandom % 16);
      logic [7:0] v = ($urandom % 2) ? 8'(8'h30 + $urandom % 48) : 8'($urandom);
      logic [7:0] td = 8'(($urandom % 8) << 4) | 8'($urandom % 16);
      int reg_sel = int'($urandom % 4);
      logic [11:0] ra = (reg_sel == 3) ? 12'h300 : 12'(12'h100 + reg_sel * 12'h80 + ($urandom % 8) * 16);
      bit a = (r < 2), e = (r == 2), tw = (r == 3), u = (r == 4 || r == 5), t = (r >= 6 && r < 12);
      if ($urandom % 8 == 0) t = 1;
      if (top_of(m_isr) == 255) e = 0;
      if (v == 8'hFF) v = 8'hFE;
      cyc(a, e, tw, td, u, v, t, v, 1'($urandom), ra);
    end

    // R7: spurious vector in service is never retired
    do_reset();
    cyc(0,0,0,0,0,0,1,8'hFF,0,12'h000);
    idle(12'h000);
    cyc(1,0,0,0,0,0,0,0,0,12'h170);
    chk("R5 vecFF", 32'(ack_vec_o), 32'hFF);
    cyc(0,1,0,0,0,0,0,0,0,12'h170);
    chk("R7 spurious kept", rd_data_o, 32'h8000_0000);

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule